// File: doc/BRIEF.md
# Serial Delay-Feedback Number Theoretic Transform Pipeline

This block computes a forward number theoretic transform (NTT) of length N over the integers modulo a prime Q. It uses decimation in frequency. The default is N = 16, Q = 17 and ROOT = 3, where ROOT is a primitive N-th root of unity modulo Q. Coefficients stream in one per clock, in natural index order, marked by a valid strobe and a frame-start strobe. The transformed frame streams out at the same rate, also one per clock. It leaves in bit-reversed index order, with its own valid strobe and a start flag on the first output.

Internally there are log2(N) radix-2 stages in series. Each stage holds L = N/2^s coefficients in a small buffer, where s runs from 1 to log2(N). Each input is paired with the element that arrived L cycles earlier:

- The modular sum of the pair goes on to the next stage.
- The modular difference, times a twiddle factor, is written back into the buffer.
- That stored difference is emitted during the next half-block.

Every sum, difference and product is reduced back into [0, Q). Frames may follow each other with no idle cycle.

Top module: `ntt_sdf_pipe`

## Requirements
- R1: While reset is high, and after reset until a frame's result appears, out_valid and out_start stay 0. A reset asserted in the middle of an input frame discards that partial frame, so it produces no output.
- R2: Output position p (0..N-1, counted from out_start) of a frame carries X[rev(p)]. Here X[k] = sum over j of x[j]·ROOT^(j·k) mod Q, and rev reverses the log2(N) index bits (for N=16, position 1 holds X[8] and position 3 holds X[12]).
- R3: Every output value lies in [0, Q), for any input values in [0, Q), including frames made only of the value Q-1.
- R4: out_start goes high on the 18th rising edge after the edge that samples input 0 of a frame. The latency is N-1+log2(N)-1 cycles: N-1 cycles of buffering plus one output register per stage after the first.
- R5: The N results of a frame leave on N consecutive cycles. out_start is high only with the first of them.
- R6: Frames presented back to back, with input 0 of a frame on the cycle after input N-1 of the previous one, are all transformed correctly. Their output bursts follow each other with no idle cycle.
- R7: Idle periods between frames are allowed if they last at least N/2 cycles. Each frame then produces exactly N valid outputs and out_valid is 0 at all other times. A frame must start on the first cycle after the previous frame's last input or after such an idle period.
- R8: In stage s, the difference formed for element j (j mod 2L < L is the earlier operand) is multiplied by ROOT^k mod Q, where k = (j mod L)·N/(2L), and the product is reduced exactly to (difference·ROOT^k) mod Q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input coefficient present this cycle |
| in_start | input | 1 | Marks input 0 of a frame (with in_valid) |
| in_data | input | $clog2(Q) (5) | Input coefficient, value in [0, Q) |
| out_valid | output | 1 | Output coefficient present this cycle |
| out_start | output | 1 | Marks output position 0 of a frame |
| out_data | output | $clog2(Q) (5) | Transform value at bit-reversed position |

## Verification
Assertions watch every cycle for several local properties:

- each stage's registered output stays below Q;
- each twiddle product equals the exact modular product;
- a draining stage never sits in its upper half-block;
- input frames start on a stage block boundary;
- the output burst has no hole and carries its start flag only at position 0.

The bench's scenarios cover what only complete frames can show: the transform values against a direct O(N²) sum for impulse, all-maximum and polynomial patterns, the 18-cycle latency, seamless back-to-back frames, exact output counts across idle gaps, and the discarding of a frame cut by reset.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

  // Modular exponentiation, used at elaboration to fill the twiddle tables.
  function automatic longint mod_pow(longint base, longint ex, longint m);
    longint r;
    longint b;
    longint e;
    r = 1 % m;
    b = base % m;
    e = ex;
    while (e > 0) begin
      if (e[0]) r = (r * b) % m;
      b = (b * b) % m;
      e = e >>> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/ntt_modmul.sv
// Combinational modular multiply with Barrett reduction against constant Q.
module ntt_modmul #(
  parameter int Q  = 17,
  parameter int DW = 5
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] p
);
  localparam int PW = 2 * DW;
  localparam int SW = 3 * DW + 1;
  localparam longint MU = (longint'(1) << PW) / Q;
  localparam logic [SW-1:0] MU_V = SW'(MU);
  localparam logic [PW:0]   Q_W  = (PW + 1)'(Q);
  localparam logic [DW+1:0] Q_R  = (DW + 2)'(Q);

  logic [PW-1:0] full;
  logic [DW:0]   est;
  logic [PW:0]   est_q;
  logic [DW+1:0] r0;
  logic [DW+1:0] r1;

  assign full  = PW'(a) * PW'(b);
  // quotient estimate, never above the true quotient, at most 2 below it
  assign est   = (DW + 1)'((SW'(full) * MU_V) >> PW);
  assign est_q = (PW + 1)'(est) * Q_W;
  assign r0    = (DW + 2)'({1'b0, full} - est_q);
  assign r1    = (r0 >= Q_R) ? (r0 - Q_R) : r0;
  assign p     = (r1 >= Q_R) ? DW'(r1 - Q_R) : DW'(r1);

endmodule

// File: rtl/ntt_butterfly.sv
// Radix-2 modular butterfly core: s = (x + y) mod Q, d = (x - y) mod Q.
module ntt_butterfly #(
  parameter int Q  = 17,
  parameter int DW = 5
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  output logic [DW-1:0] s,
  output logic [DW-1:0] d
);
  localparam logic [DW:0] Q_E = (DW + 1)'(Q);

  logic [DW:0] raw_s;
  logic [DW:0] raw_d;

  assign raw_s = {1'b0, x} + {1'b0, y};
  assign s     = (raw_s >= Q_E) ? DW'(raw_s - Q_E) : DW'(raw_s);
  // x + Q - y stays in (0, 2Q) for operands already in [0, Q)
  assign raw_d = {1'b0, x} + Q_E - {1'b0, y};
  assign d     = (raw_d >= Q_E) ? DW'(raw_d - Q_E) : DW'(raw_d);

endmodule

// File: rtl/ntt_sdf_stage.sv
// One delay-feedback DIF stage: buffer of L entries, butterfly, twiddle multiply.
module ntt_sdf_stage #(
  parameter int N    = 16,
  parameter int Q    = 17,
  parameter int ROOT = 3,
  parameter int DW   = 5,
  parameter int L    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_start,
  output logic [DW-1:0] out_data
);
  localparam int IW     = $clog2(2 * L);
  localparam int AW     = (L > 1) ? $clog2(L) : 1;
  localparam int DEPTH  = 1 << AW;
  localparam int STRIDE = N / (2 * L);
  localparam logic [IW-1:0] POS_HALF_END = IW'(L - 1);
  localparam logic [IW-1:0] POS_UPPER    = IW'(L);
  localparam logic [IW-1:0] POS_BLK_END  = IW'(2 * L - 1);

  logic [IW-1:0] pos_q;      // position inside the current 2L block
  logic          tail_q;     // buffer holds differences not yet emitted
  logic          sflag_q;    // frame start seen, first sum not yet emitted
  logic          half1;
  logic          drain;
  logic          adv;
  logic          emit;
  logic          emit_first;
  logic [AW-1:0] addr;
  logic [DW-1:0] rd;
  logic [DW-1:0] tw;
  logic [DW-1:0] sum;
  logic [DW-1:0] diff;
  logic [DW-1:0] prod;
  logic [DW-1:0] wd;

  // twiddle table: entry e holds ROOT^(e*STRIDE) mod Q
  logic [DW-1:0] tw_rom [DEPTH];
  for (genvar e = 0; e < DEPTH; e++) begin : g_tw
    assign tw_rom[e] = DW'(ntt_pkg::mod_pow(longint'(ROOT), longint'(e * STRIDE), longint'(Q)));
  end

  if (L > 1) begin : g_addr
    assign addr = pos_q[AW-1:0];
  end else begin : g_addr1
    assign addr = 1'b0;
  end

  assign half1 = pos_q[IW-1];
  assign drain = tail_q & ~in_valid;
  assign adv   = in_valid | drain;

  // feedback buffer: one write port, asynchronous read (distributed RAM)
  logic [DW-1:0] mem [DEPTH];
  assign rd = mem[addr];
  assign tw = tw_rom[addr];

  always_ff @(posedge clk) begin
    if (in_valid) mem[addr] <= wd;
  end

  ntt_butterfly #(.Q(Q), .DW(DW)) u_bfly (
    .x (rd),
    .y (in_data),
    .s (sum),
    .d (diff)
  );

  ntt_modmul #(.Q(Q), .DW(DW)) u_mul (
    .a (diff),
    .b (tw),
    .p (prod)
  );

  // lower half: park the new element; upper half: park the twiddled difference
  assign wd         = half1 ? prod : in_data;
  assign emit       = (in_valid & half1) | (adv & ~half1 & tail_q);
  assign emit_first = in_valid & half1 & (pos_q == POS_UPPER) & sflag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '0;
      tail_q    <= 1'b0;
      sflag_q   <= 1'b0;
      out_valid <= 1'b0;
      out_start <= 1'b0;
      out_data  <= '0;
    end else begin
      if (adv) pos_q <= (drain && pos_q == POS_HALF_END) ? '0 : pos_q + 1'b1;
      if (in_valid && pos_q == POS_BLK_END) tail_q <= 1'b1;
      else if (adv && pos_q == POS_HALF_END) tail_q <= 1'b0;
      if (in_valid && in_start) sflag_q <= 1'b1;
      else if (emit_first) sflag_q <= 1'b0;
      out_valid <= emit;
      out_start <= emit_first;
      if (emit) out_data <= half1 ? sum : rd;
    end
  end

  p_out_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (int'(out_data) < Q));

  p_mult_exact_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half1) |-> (int'(prod) == (int'(diff) * int'(tw)) % Q));

  p_start_block_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start) |-> (pos_q == '0));

  p_drain_half0_r7: assert property (@(posedge clk) disable iff (rst)
    drain |-> !half1);

  p_start_valid_r5: assert property (@(posedge clk) disable iff (rst)
    out_start |-> out_valid);

endmodule

// File: rtl/ntt_sdf_pipe.sv
// Top: log2(N) delay-feedback stages in series, one coefficient per clock.
module ntt_sdf_pipe #(
  parameter int N    = 16,
  parameter int Q    = 17,
  parameter int ROOT = 3,
  localparam int DW  = $clog2(Q)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic          out_start,
  output logic [DW-1:0] out_data
);
  localparam int LOGN = $clog2(N);

  logic [LOGN:0] v_s;
  logic [LOGN:0] st_s;
  logic [DW-1:0] d_s [LOGN+1];

  assign v_s[0]  = in_valid;
  assign st_s[0] = in_start;
  assign d_s[0]  = in_data;

  for (genvar g = 0; g < LOGN; g++) begin : g_stage
    ntt_sdf_stage #(
      .N    (N),
      .Q    (Q),
      .ROOT (ROOT),
      .DW   (DW),
      .L    (N >> (g + 1))
    ) u_stage (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (v_s[g]),
      .in_start  (st_s[g]),
      .in_data   (d_s[g]),
      .out_valid (v_s[g+1]),
      .out_start (st_s[g+1]),
      .out_data  (d_s[g+1])
    );
  end

  assign out_valid = v_s[LOGN];
  assign out_start = st_s[LOGN];
  assign out_data  = d_s[LOGN];

  // output position tracker, used only by the burst checks below
  logic [LOGN-1:0] opos_q;
  always_ff @(posedge clk) begin
    if (rst) opos_q <= '0;
    else if (out_valid) opos_q <= opos_q + 1'b1;
  end

  p_burst_start_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_start == (opos_q == '0)));

  p_burst_nohole_r5: assert property (@(posedge clk) disable iff (rst)
    (opos_q != '0) |-> out_valid);

endmodule

// File: tb/ntt_sdf_pipe_tb_top.sv
module ntt_sdf_pipe_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 16;
  localparam int Q    = 17;
  localparam int ROOT = 3;
  localparam int DW   = $clog2(Q);
  localparam int LOGN = $clog2(N);
  localparam int LAT  = N - 1 + LOGN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_start = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic out_start;
  logic [DW-1:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  longint cyc = 0;

  int     frm [8][16];
  longint drv_cyc [8];
  int     cap_data [256];
  bit     cap_start [256];
  longint cap_cyc [256];
  int     cap_n = 0;

  ntt_sdf_pipe #(.N(N), .Q(Q), .ROOT(ROOT)) dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_start (in_start),
    .in_data (in_data), .out_valid (out_valid), .out_start (out_start),
    .out_data (out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && out_valid && cap_n < 256) begin
      cap_data[cap_n]  = int'(out_data);
      cap_start[cap_n] = out_start;
      cap_cyc[cap_n]   = cyc;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint pw(longint b, longint e);
    longint r = 1;
    for (longint i = 0; i < e; i++) r = (r * b) % Q;
    return r;
  endfunction

  function automatic int brev(int v);
    int r = 0;
    for (int b = 0; b < LOGN; b++) if (v & (1 << b)) r |= 1 << (LOGN - 1 - b);
    return r;
  endfunction

  function automatic int ref_val(int idx, int k);
    longint acc = 0;
    for (int j = 0; j < N; j++) acc = (acc + longint'(frm[idx][j]) * pw(ROOT, j * k)) % Q;
    return int'(acc);
  endfunction

  task automatic build(input int idx, input int a, input int b, input int c);
    for (int j = 0; j < N; j++) frm[idx][j] = (a * j + b * j * j + c) % Q;
  endtask

  task automatic send_frame(input int idx);
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (j == 0);
      in_data  = DW'(frm[idx][j]);
      if (j == 0) drv_cyc[idx] = cyc;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_start = 1'b0;
    end
  endtask

  task automatic wait_caps(input int target);
    int t = 0;
    while (cap_n < target && t < 400) begin
      @(negedge clk);
      t++;
    end
    idle(2 * N);
  endtask

  // checks data (R2), burst shape (R5) and latency (R4) for cnt frames
  task automatic check_frames(input int base, input int first, input int cnt);
    for (int f = 0; f < cnt; f++) begin
      int o = base + f * N;
      bit st_ok = 1'b1;
      bit ct_ok = 1'b1;
      for (int p = 0; p < N; p++) begin
        int e = ref_val(first + f, brev(p));
        chk(cap_data[o + p] == e, "R2/R8", $sformatf("frame %0d pos %0d", first + f, p),
            cap_data[o + p], e);
        chk(cap_data[o + p] < Q, "R3", "range", cap_data[o + p], Q - 1);
        if (cap_start[o + p] != (p == 0)) st_ok = 1'b0;
        if (cap_cyc[o + p] != cap_cyc[o] + p) ct_ok = 1'b0;
      end
      chk(st_ok, "R5", "out_start only at position 0", st_ok, 1);
      chk(ct_ok, "R5", "burst consecutive", ct_ok, 1);
      chk(cap_cyc[o] - drv_cyc[first + f] == LAT + 1, "R4", "latency",
          cap_cyc[o] - drv_cyc[first + f] - 1, LAT);
    end
  endtask

  task automatic t_reset();
    bit quiet = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (out_valid || out_start) quiet = 1'b0;
    end
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (out_valid || out_start) quiet = 1'b0;
    end
    chk(quiet, "R1", "outputs low in and after reset", quiet, 1);
  endtask

  task automatic t_impulse();
    int base = cap_n;
    for (int j = 0; j < N; j++) frm[0][j] = (j == 0);
    send_frame(0);
    idle(1);
    wait_caps(base + N);
    check_frames(base, 0, 1);
    chk(cap_n == base + N, "R7", "impulse output count", cap_n - base, N);
  endtask

  task automatic t_max_values();
    int base = cap_n;
    for (int j = 0; j < N; j++) frm[1][j] = Q - 1;
    send_frame(1);
    idle(1);
    wait_caps(base + N);
    check_frames(base, 1, 1);
  endtask

  task automatic t_back_to_back();
    int base = cap_n;
    build(2, 3, 5, 7);
    build(3, 11, 2, 1);
    build(4, 6, 13, 16);
    send_frame(2);
    send_frame(3);
    send_frame(4);
    idle(1);
    wait_caps(base + 3 * N);
    check_frames(base, 2, 3);
    chk(cap_cyc[base + 2 * N] == cap_cyc[base] + 2 * N, "R6", "bursts abut",
        cap_cyc[base + 2 * N] - cap_cyc[base], 2 * N);
    chk(cap_n == base + 3 * N, "R6", "back-to-back output count", cap_n - base, 3 * N);
  endtask

  task automatic t_gaps();
    int base = cap_n;
    build(5, 9, 4, 14);
    build(6, 1, 16, 3);
    send_frame(5);
    idle(N / 2);
    send_frame(6);
    idle(1);
    wait_caps(base + 2 * N);
    check_frames(base, 5, 2);
    chk(cap_n == base + 2 * N, "R7", "gapped output count", cap_n - base, 2 * N);
    chk(!cap_start[base + N] || cap_cyc[base + N] - cap_cyc[base + N - 1] == N / 2 + 1,
        "R7", "idle cycles between bursts", cap_cyc[base + N] - cap_cyc[base + N - 1] - 1, N / 2);
  endtask

  task automatic t_reset_mid_frame();
    int base;
    build(7, 2, 9, 5);
    for (int j = 0; j < N / 2 + 3; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_start = (j == 0);
      in_data  = DW'(frm[7][(j + 5) % N]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_start = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    base = cap_n;
    idle(3 * N);
    chk(cap_n == base, "R1", "cut frame produces no output", cap_n - base, 0);
    send_frame(7);
    idle(1);
    wait_caps(base + N);
    check_frames(base, 7, 1);
  endtask

  initial begin
    t_reset();
    t_impulse();
    t_max_values();
    t_back_to_back();
    t_gaps();
    t_reset_mid_frame();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d captures expected completion", cap_n);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule